// File: doc/BRIEF.md
# MIDI Note Message Decoder

This block sits behind a serial byte receiver and turns its stream of bytes into three-byte MIDI channel messages. Each byte arrives with a one-cycle valid strobe. A byte with its top bit set is a status byte, and one with its top bit clear is a data byte. The decoder keeps the most recent key-press or key-release command and collects the key number and the strike strength that follow it. When a key-press message with a nonzero strength is complete, the key number is latched onto seven output lines that drive indicator LEDs in binary.

Every completed key-press or key-release message raises a one-cycle done pulse and updates the velocity output. The decoder also supports running status, which means a new data pair reuses the last key command without a new status byte. Real-time bytes are transparent to the decoder. Other status bytes, stray data and receiver framing errors make the decoder drop what it has and wait for a fresh status byte.

Top module: `midi_note_decoder`

## Requirements
- R1: After reset, `note_leds` is 0, `note_vel` is 0, `msg_done` is 0, and no message is in progress.
- R2: A status byte with upper nibble 0x9 (key pressed, any channel in the lower nibble), then a key byte, then a nonzero velocity byte, latches key[6:0] onto `note_leds`. The same message puts the velocity on `note_vel` and drives `msg_done` high for the cycle after the velocity byte is accepted.
- R3: A key-press message (0x9n) with velocity 0 still pulses `msg_done` and sets `note_vel` to 0, but leaves `note_leds` unchanged.
- R4: A key-release message (upper nibble 0x8) pulses `msg_done` and updates `note_vel`, and leaves `note_leds` unchanged.
- R5: Data bytes (bit 7 = 0) that arrive with no active status byte are discarded. They cause no `msg_done` and no output change.
- R6: A status byte that arrives partway through a message drops the partial message, and assembly restarts under the new status.
- R7: After a completed message, each further pair of data bytes forms a new message under the last 0x9n or 0x8n status (running status).
- R8: Any other status byte from 0xA0 to 0xF7 ends running status, and the data bytes after it are discarded.
- R9: Real-time bytes (0xF8 to 0xFF) are ignored. They do not disturb a message in progress or running status.
- R10: A high `frame_err` drops the partial message and the running status, so the decoder waits for a new status byte. A byte strobed in the same cycle as `frame_err` is discarded.
- R11: `msg_done` is never high in two consecutive cycles, even when bytes arrive on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | One-cycle strobe marking a received byte |
| byte_data | input | 8 | Received byte |
| frame_err | input | 1 | Receiver framing-error indication |
| note_leds | output | 7 | Key number of the last sounding key-press, in binary |
| note_vel | output | 7 | Velocity of the last completed message |
| msg_done | output | 1 | One-cycle pulse per completed key-press or key-release message |

## Verification
On every cycle, the assertions check four things. The LED lines change only together with a done pulse that carries a nonzero velocity. The done pulse is always a single cycle and always follows an accepted data byte. A framing error or an unmatched data byte leaves the decoder idle. Which LED value and velocity each byte sequence should produce can only be shown by the bench's scenarios. These scenarios cover the channel nibble being ignored, zero-velocity presses, key releases, restarts, running status surviving real-time bytes, and running status ending after other status bytes.

// File: rtl/midi_note_decoder.sv
module midi_note_decoder #(
  parameter int          KEY_W    = 7,
  parameter logic [3:0]  CMD_ON   = 4'h9,
  parameter logic [3:0]  CMD_OFF  = 4'h8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [KEY_W:0]   byte_data,
  input  logic             frame_err,
  output logic [KEY_W-1:0] note_leds,
  output logic [KEY_W-1:0] note_vel,
  output logic             msg_done
);
  localparam int BW = KEY_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_KEY, S_VEL} st_t;

  st_t              state;
  logic             run_on;
  logic [KEY_W-1:0] key_q;

  wire             is_status = byte_data[BW-1];
  wire             is_rt     = &byte_data[BW-1:BW-5];
  wire [3:0]       cmd       = byte_data[BW-1:BW-4];
  wire [KEY_W-1:0] payload   = byte_data[KEY_W-1:0];
  wire             take      = byte_valid && !frame_err && !is_rt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      run_on    <= 1'b0;
      key_q     <= '0;
      note_leds <= '0;
      note_vel  <= '0;
      msg_done  <= 1'b0;
    end else begin
      msg_done <= 1'b0;
      if (frame_err) begin
        state <= S_IDLE;
      end else if (take) begin
        if (is_status) begin
          if (cmd == CMD_ON || cmd == CMD_OFF) begin
            state  <= S_KEY;
            run_on <= (cmd == CMD_ON);
          end else begin
            state <= S_IDLE;
          end
        end else begin
          case (state)
            S_KEY: begin
              key_q <= payload;
              state <= S_VEL;
            end
            S_VEL: begin
              note_vel <= payload;
              msg_done <= 1'b1;
              if (run_on && payload != '0) note_leds <= key_q;
              state <= S_KEY;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_leds_move_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(note_leds) |-> (msg_done && note_vel != '0));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done);

  assert_done_after_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> $past(byte_valid && !byte_data[BW-1] && !frame_err));

  assert_abort_on_frame_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> (state == S_IDLE && !msg_done));

  assert_stray_data_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && byte_valid && !byte_data[BW-1]) |=> (state == S_IDLE && !msg_done));

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);
endmodule

// File: tb/midi_note_decoder_tb.sv
`timescale 1ns/1ps
module midi_note_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       frame_err = 1'b0;
  logic [6:0] note_leds, note_vel;
  logic       msg_done;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  logic [6:0] exp_leds_q[$];
  logic [6:0] exp_vel_q[$];
  string      exp_req_q[$];

  always #2.5 clk = ~clk;

  midi_note_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_err(frame_err), .note_leds(note_leds), .note_vel(note_vel), .msg_done(msg_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_msg(input logic [6:0] leds, input logic [6:0] vel, input string req);
    exp_leds_q.push_back(leds);
    exp_vel_q.push_back(vel);
    exp_req_q.push_back(req);
  endtask

  task automatic send(input logic [7:0] b, input bit fe = 1'b0);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = b; frame_err = fe;
    @(negedge clk);
    byte_valid = 1'b0; frame_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_fe();
    @(negedge clk); frame_err = 1'b1;
    @(negedge clk); frame_err = 1'b0;
  endtask

  task automatic burst3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk); byte_valid = 1'b1; byte_data = a;
    @(negedge clk); byte_data = b;
    @(negedge clk); byte_data = c;
    @(negedge clk); byte_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet_check(input logic [6:0] leds, input string req);
    repeat (3) @(negedge clk);
    check(note_leds == leds, req, note_leds, leds);
    check(exp_leds_q.size() == 0, req, exp_leds_q.size(), 0);
  endtask

  // monitor / scoreboard
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && msg_done) check(1'b0, "R11 double pulse", 1, 0);
      if (msg_done) begin
        if (exp_leds_q.size() == 0) begin
          check(1'b0, "unexpected msg_done R5/R8/R10", 1, 0);
        end else begin
          automatic logic [6:0] el = exp_leds_q.pop_front();
          automatic logic [6:0] ev = exp_vel_q.pop_front();
          automatic string      rq = exp_req_q.pop_front();
          check(note_leds == el, {rq, " leds"}, note_leds, el);
          check(note_vel == ev, {rq, " vel"}, note_vel, ev);
        end
      end
    end
    prev_done <= msg_done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(note_leds == 0, "R1 leds", note_leds, 0);
    check(note_vel == 0, "R1 vel", note_vel, 0);
    check(msg_done == 0, "R1 done", msg_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(8'h40); send(8'h41);
    quiet_check(7'h00, "R5 stray data");

    expect_msg(7'h3C, 7'h64, "R2");
    send(8'h93); send(8'h3C); send(8'h64);

    expect_msg(7'h45, 7'h20, "R7 running on");
    send(8'h45); send(8'h20);

    expect_msg(7'h45, 7'h00, "R3 zero velocity");
    send(8'h90); send(8'h50); send(8'h00);

    expect_msg(7'h45, 7'h40, "R4 release");
    send(8'h8F); send(8'h10); send(8'h40);
    expect_msg(7'h45, 7'h22, "R7 running off");
    send(8'h11); send(8'h22);
    quiet_check(7'h45, "R4 leds held");

    send(8'h91); send(8'h30); pulse_fe(); send(8'h31);
    quiet_check(7'h45, "R10 abort");
    send(8'h32); send(8'h33);
    quiet_check(7'h45, "R10 running dropped");
    send(8'h92, 1'b1); send(8'h12); send(8'h34);
    quiet_check(7'h45, "R10 byte with error");

    send(8'hA0); send(8'h10); send(8'h20);
    quiet_check(7'h45, "R8 other status");
    expect_msg(7'h07, 7'h08, "R8 recovery");
    send(8'h9A); send(8'h07); send(8'h08);
    send(8'hF0); send(8'h55); send(8'h56);
    quiet_check(7'h07, "R8 sysex ends running");

    expect_msg(7'h22, 7'h33, "R6 restart");
    send(8'h90); send(8'h11); send(8'h94); send(8'h22); send(8'h33);

    expect_msg(7'h61, 7'h70, "R9 realtime");
    send(8'h95); send(8'hF8); send(8'h61); send(8'hFE); send(8'h70);
    expect_msg(7'h62, 7'h71, "R9 running kept");
    send(8'hFF); send(8'h62); send(8'h71);

    expect_msg(7'h01, 7'h02, "R11 burst");
    burst3(8'h9F, 8'h01, 8'h02);
    expect_msg(7'h03, 7'h04, "R11 burst running");
    @(negedge clk); byte_valid = 1'b1; byte_data = 8'h03;
    @(negedge clk); byte_data = 8'h04;
    @(negedge clk); byte_valid = 1'b0;
    repeat (3) @(negedge clk);

    check(exp_leds_q.size() == 0, "R2 all messages seen", exp_leds_q.size(), 0);
    check(note_leds == 7'h03, "R2 final leds", note_leds, 7'h03);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule